// File: doc/BRIEF.md
# RV32I Integer Arithmetic-Logic Unit

This block is the integer execute unit of a 32-bit RISC-V core that finishes each instruction in one cycle. It takes two operands and a four-bit operation code, and returns a result word and a flag that is set when that result is zero. It holds no state: every output is a function of the present inputs, so the result is ready in the same cycle the operands arrive.

The register-register and the register-immediate instruction groups both use the same datapath. For the immediate forms, the decoder places the sign-extended immediate on operand B and selects the matching operation. There is no subtract-immediate instruction, so the subtract code only ever appears with two register operands.

One adder serves add, subtract and both compares. A staged shifter handles all three shift kinds. A small bitwise unit covers AND, OR and XOR. A final select picks the result. The block does not decode immediates, read registers, multiply, divide or raise exceptions.

Top module: `rv_int_alu`

## Requirements
- R1: Operation code 0 (add) returns the sum of A and B modulo 2^32.
- R2: Operation code 1 (subtract) returns A minus B modulo 2^32.
- R3: Operation code 2 (signed set-less-than) returns 1 when A is less than B as two's-complement values, and 0 otherwise.
- R4: Operation code 3 (unsigned set-less-than) returns 1 when A is less than B as unsigned values, and 0 otherwise.
- R5: Operation codes 4, 5 and 6 return the bitwise AND, OR and XOR of A and B.
- R6: Operation code 7 (shift left) shifts A left by B[4:0] and fills the vacated positions with zeros. Bits 31:5 of B have no effect on the result.
- R7: Operation code 8 (logical shift right) shifts A right by B[4:0] and fills the vacated positions with zeros. Bits 31:5 of B are ignored.
- R8: Operation code 9 (arithmetic shift right) shifts A right by B[4:0] and fills the vacated positions with copies of A[31]. Bits 31:5 of B are ignored.
- R9: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R10: Operation codes 10 to 15 are unused. They return a result of 0, so the zero output reads 1.
- R11: The outputs depend only on the present inputs, and a new input value is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand, always a register value |
| opnd_b | input | 32 | Second operand: a register value or a sign-extended immediate |
| alu_op | input | 4 | Operation code, encoded as listed in the requirements |
| result | output | 32 | Result of the selected operation |
| zero | output | 1 | Set when the result is all zeros |

## Verification
The bench builds the unit with its default 32-bit word width, which gives a five-bit shift field. At that width, every shift amount from 0 to 31 and the ignored upper bits of B can all be reached. The directed operands 0, 1, 0x7FFFFFFF, 0x80000000 and all-ones are used because they are where the signed and unsigned compares disagree, where add and subtract wrap, and where an arithmetic shift fills with ones. Random operands paired with every code, including the unused ones, then cover the general behaviour.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLT  = 4'd2,
        OP_SLTU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LOGIC_AND = 2'd0,
        LOGIC_OR  = 2'd1,
        LOGIC_XOR = 2'd2
    } logic_sel_e;

    typedef enum logic [2:0] {
        PICK_SUM   = 3'd0,
        PICK_LTS   = 3'd1,
        PICK_LTU   = 3'd2,
        PICK_LOGIC = 3'd3,
        PICK_SHIFT = 3'd4,
        PICK_NONE  = 3'd5
    } pick_e;

    typedef struct packed {
        logic       sub;
        logic       left;
        logic       arith;
        logic_sel_e lsel;
        pick_e      pick;
    } alu_ctrl_t;

endpackage

// File: rtl/rv_alu_addsub.sv
module rv_alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] sum,
    output logic            lt_s,
    output logic            lt_u
);
    localparam int WIDE = XLEN + 1;

    logic [XLEN-1:0] b_eff;
    logic [WIDE-1:0] total;

    always_comb begin
        b_eff = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
        sum   = total[XLEN-1:0];
        // Unsigned borrow: no carry out of A + ~B + 1 means A < B.
        lt_u  = ~total[XLEN];
        // Signed: differing signs decide directly, else the difference sign.
        if (a[XLEN-1] != b[XLEN-1])
            lt_s = a[XLEN-1];
        else
            lt_s = total[XLEN-1];
    end
endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         a,
    input  logic [$clog2(XLEN)-1:0] amount,
    input  logic                    left,
    input  logic                    arith,
    output logic [XLEN-1:0]         out
);
    localparam int SHW = $clog2(XLEN);

    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    // Left shift reuses the right-shift network on bit-reversed data.
    generate
        for (genvar i = 0; i < XLEN; i++) begin : g_rev
            assign rev_in[i]  = a[XLEN-1-i];
            assign rev_out[i] = stage[SHW][XLEN-1-i];
        end
    endgenerate

    assign fill     = arith & ~left & a[XLEN-1];
    assign stage[0] = left ? rev_in : a;

    generate
        for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int STEP = 1 << k;
            assign stage[k+1] = amount[k]
                ? {{STEP{fill}}, stage[k][XLEN-1:STEP]}
                : stage[k];
        end
    endgenerate

    assign out = left ? rev_out : stage[SHW];
endmodule

// File: rtl/rv_alu_logic.sv
module rv_alu_logic
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic_sel_e      sel,
    output logic [XLEN-1:0] out
);
    always_comb begin
        case (sel)
            LOGIC_AND: out = a & b;
            LOGIC_OR:  out = a | b;
            LOGIC_XOR: out = a ^ b;
            default:   out = '0;
        endcase
    end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import rv_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [3:0]      alu_op,
    output logic [XLEN-1:0] result,
    output logic            zero
);
    localparam int SHW = $clog2(XLEN);

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] sum_w;
    logic [XLEN-1:0] logic_w;
    logic [XLEN-1:0] shift_w;
    logic            lts_w;
    logic            ltu_w;

    // Operation decode into datapath controls.
    always_comb begin
        ctrl = '{sub: 1'b0, left: 1'b0, arith: 1'b0,
                 lsel: LOGIC_AND, pick: PICK_NONE};
        case (alu_op)
            OP_ADD:  ctrl.pick = PICK_SUM;
            OP_SUB:  begin ctrl.sub = 1'b1; ctrl.pick = PICK_SUM; end
            OP_SLT:  begin ctrl.sub = 1'b1; ctrl.pick = PICK_LTS; end
            OP_SLTU: begin ctrl.sub = 1'b1; ctrl.pick = PICK_LTU; end
            OP_AND:  begin ctrl.lsel = LOGIC_AND; ctrl.pick = PICK_LOGIC; end
            OP_OR:   begin ctrl.lsel = LOGIC_OR;  ctrl.pick = PICK_LOGIC; end
            OP_XOR:  begin ctrl.lsel = LOGIC_XOR; ctrl.pick = PICK_LOGIC; end
            OP_SLL:  begin ctrl.left = 1'b1; ctrl.pick = PICK_SHIFT; end
            OP_SRL:  ctrl.pick = PICK_SHIFT;
            OP_SRA:  begin ctrl.arith = 1'b1; ctrl.pick = PICK_SHIFT; end
            default: ctrl.pick = PICK_NONE;
        endcase
    end

    rv_alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .sub  (ctrl.sub),
        .sum  (sum_w),
        .lt_s (lts_w),
        .lt_u (ltu_w)
    );

    rv_alu_shift #(.XLEN(XLEN)) u_shift (
        .a      (opnd_a),
        .amount (opnd_b[SHW-1:0]),
        .left   (ctrl.left),
        .arith  (ctrl.arith),
        .out    (shift_w)
    );

    rv_alu_logic #(.XLEN(XLEN)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (ctrl.lsel),
        .out (logic_w)
    );

    // Result select.
    always_comb begin
        case (ctrl.pick)
            PICK_SUM:   result = sum_w;
            PICK_LTS:   result = {{(XLEN-1){1'b0}}, lts_w};
            PICK_LTU:   result = {{(XLEN-1){1'b0}}, ltu_w};
            PICK_LOGIC: result = logic_w;
            PICK_SHIFT: result = shift_w;
            default:    result = '0;
        endcase
    end

    assign zero = ~|result;
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
    parameter int XLEN = 32
) (
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [3:0]      alu_op,
    input logic [XLEN-1:0] result,
    input logic            zero
);
    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0]  sh;
    logic [XLEN-1:0] ones;

    assign sh   = opnd_b[SHW-1:0];
    assign ones = '1;

    always_comb begin
        // R9: flag agrees with the result word
        assert_zero_flag_R9: assert (zero == (result == '0));
        // R1: sum minus B gives back A
        if (alu_op == 4'd0)
            assert_add_inverse_R1: assert (result - opnd_b == opnd_a);
        // R2: difference plus B gives back A
        if (alu_op == 4'd1)
            assert_sub_inverse_R2: assert (result + opnd_b == opnd_a);
        // R3: signed compare yields a single bit
        if (alu_op == 4'd2)
            assert_slt_bool_R3: assert (result[XLEN-1:1] == '0);
        // R4: unsigned compare yields a single bit
        if (alu_op == 4'd3)
            assert_sltu_bool_R4: assert (result[XLEN-1:1] == '0);
        // R6: vacated low bits are zero
        if (alu_op == 4'd7)
            assert_sll_fill_R6: assert ((result & ~(ones << sh)) == '0);
        // R7: vacated high bits are zero
        if (alu_op == 4'd8)
            assert_srl_fill_R7: assert ((result & ~(ones >> sh)) == '0);
        // R8: negative operand fills high bits with ones
        if (alu_op == 4'd9 && opnd_a[XLEN-1])
            assert_sra_fill_R8: assert ((result | (ones >> sh)) == ones);
        // R10: unused codes produce zero
        if (alu_op > 4'd9)
            assert_unused_zero_R10: assert (result == '0 && zero);
    end
endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .alu_op (alu_op),
    .result (result),
    .zero   (zero)
);

// File: tb/tb_rv_int_alu.sv
`timescale 1ns/1ps
module tb_rv_int_alu;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [3:0]      op;
    logic [XLEN-1:0] res;
    logic            zf;
    int              checks = 0;
    int              errors = 0;
    bit              done   = 1'b0;

    always #2.5 clk = ~clk;

    rv_int_alu #(.XLEN(XLEN)) dut (
        .opnd_a (a),
        .opnd_b (b),
        .alu_op (op),
        .result (res),
        .zero   (zf)
    );

    function automatic logic [XLEN-1:0] model(input logic [3:0] o,
                                              input logic [XLEN-1:0] x,
                                              input logic [XLEN-1:0] y);
        case (o)
            4'd0: model = x + y;
            4'd1: model = x - y;
            4'd2: model = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            4'd3: model = (x < y) ? 32'd1 : 32'd0;
            4'd4: model = x & y;
            4'd5: model = x | y;
            4'd6: model = x ^ y;
            4'd7: model = x << y[4:0];
            4'd8: model = x >> y[4:0];
            4'd9: model = $unsigned($signed(x) >>> y[4:0]);
            default: model = '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: req_of = "R1";
            4'd1: req_of = "R2";
            4'd2: req_of = "R3";
            4'd3: req_of = "R4";
            4'd4, 4'd5, 4'd6: req_of = "R5";
            4'd7: req_of = "R6";
            4'd8: req_of = "R7";
            4'd9: req_of = "R8";
            default: req_of = "R10";
        endcase
    endfunction

    task automatic apply(input logic [3:0] o, input logic [XLEN-1:0] x,
                         input logic [XLEN-1:0] y);
        logic [XLEN-1:0] exp_r;
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
        exp_r = model(o, x, y);
        checks++;
        if (res !== exp_r) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                     req_of(o), o, x, y, res, exp_r);
        end
        checks++;
        if (zf !== (exp_r == '0)) begin
            errors++;
            $display("FAIL R9 op=%0d a=%h b=%h actual=%b expected=%b",
                     o, x, y, zf, (exp_r == '0));
        end
    endtask

    initial begin
        logic [XLEN-1:0] corners [6];
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF;
        corners[5] = 32'h0000_001F;
        void'($urandom(32'd20240611));
        op = 4'd0; a = '0; b = '0;
        // Initial-state check: zero inputs with add give a zero result.
        #1;
        checks++;
        if (res !== '0 || zf !== 1'b1) begin
            errors++;
            $display("FAIL R9 initial actual=%h/%b expected=0/1", res, zf);
        end
        // R11: a change with no clock edge between is seen at once.
        a = 32'd5; b = 32'd7; #0.5;
        checks++;
        if (res !== 32'd12) begin
            errors++;
            $display("FAIL R11 actual=%h expected=%h", res, 32'd12);
        end
        // Directed corners for every code, including unused ones (R10).
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    apply(4'(o), corners[i], corners[j]);
        // R6 R7 R8: upper bits of B must not change the shift.
        for (int s = 0; s < 32; s++) begin
            apply(4'd7, 32'h8421_F00F, {27'h5A5A5A5, 5'(s)});
            apply(4'd8, 32'h8421_F00F, {27'h7FFFFFF, 5'(s)});
            apply(4'd9, 32'h8421_F00F, {27'h1234567, 5'(s)});
            apply(4'd9, 32'h7421_F00F, {27'h0000001, 5'(s)});
        end
        // R3 R4: equal operands and near-equal values.
        apply(4'd2, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        apply(4'd3, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        apply(4'd2, 32'h1234_5678, 32'h1234_5678);
        apply(4'd1, 32'h1234_5678, 32'h1234_5678);
        // Random operands over every code.
        for (int n = 0; n < 400; n++)
            for (int o = 0; o < 16; o++)
                apply(4'(o), $urandom(), $urandom());
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule